// File: doc/BRIEF.md
# Serial ADC Capture and Channel Sequencer

This block runs a 16-bit successive-approximation converter that has a serial output, and passes each finished sample to a host processor as a parallel word. The host controls a single enable level. While that level is high the block runs conversions back to back. For each conversion it pulls chip select low to wake the converter and waits out the wake-up time. It then clocks in sixteen bits on rising serial clock edges, because the converter changes its output on falling edges. Finally it stores the word in a result register and raises a one-cycle ready pulse.

A configuration byte sets the range of channels. Its low three bits hold the first channel and the next three bits hold the last channel. A 3-bit channel output steps round-robin from the first channel to the last one, then starts again at the first. The channel output changes only after a result has been stored, so the host can read the channel next to the word it belongs to. A configuration whose last channel is below its first channel is treated as a single channel.

Top module: `serial_adc_seq`

## Requirements
- R1: While synchronous reset is high and on the cycle after it, chip select reads 1, serial clock reads 0, the result register reads 0, ready reads 0 and the channel output equals configuration bits 2:0.
- R2: While the enable input is low, chip select stays 1, the serial clock stays 0, no ready pulse appears and the channel output holds configuration bits 2:0.
- R3: A conversion begins with chip select going from 1 to 0. No rising serial clock edge follows within WAKE_CYCLES system clocks (224 by default, which is 1.12 µs at 200 MHz).
- R4: Each conversion has exactly 16 rising serial clock edges. Each high and low phase lasts SCLK_DIV system clocks. The serial line is sampled on each rising edge, and the first bit sampled becomes bit 15 of the result.
- R5: Once the 16th bit is in, the result register takes the new word and ready goes high in that same cycle, for exactly one cycle. The result register never changes in a cycle where ready is low.
- R6: Between two conversions chip select stays 1 for at least two serial clock periods (4·SCLK_DIV system clocks).
- R7: Configuration bits 2:0 give the first channel and bits 5:3 give the last channel. Bits 7:6 have no effect. The channel output steps up by one after each stored result and returns to the first channel after the last channel.
- R8: When the last channel is less than the first channel, every conversion uses the first channel.
- R9: The channel output does not change while chip select is 0 or in the cycle where ready is high. It steps in the cycle after the ready pulse.
- R10: If enable falls during a conversion, chip select goes to 1 in the next cycle. The partial word is then discarded: no ready pulse appears and the result register keeps its old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hostEnable | input | 1 | Host run flag; low stops and aborts conversions |
| cfgWord | input | 8 | Channel range: [2:0] first, [5:3] last, [7:6] ignored |
| adcDout | input | 1 | Serial data from the converter |
| adcCsN | output | 1 | Active-low chip select to the converter |
| adcSclk | output | 1 | Serial clock to the converter, idle low |
| chanSel | output | 3 | Channel being converted or just stored |
| resultData | output | 16 | Last stored conversion word |
| dataReady | output | 1 | One-cycle pulse when resultData updates |

## Verification
The hardest case to reach from the ports is an aborted conversion. Enable has to drop after some bits have been shifted in but before the word is stored, and the host must then see neither a ready pulse nor a changed result. The bench waits for chip select to fall, counts five rising serial clock edges, lowers enable between clock edges, and then watches the outputs for several hundred cycles. The channel wrap and the reversed-range case come from table rows whose channel sequences cross the last channel.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  // Strobes from the sequencer control to the datapath
  typedef struct packed {
    logic shiftEn;   // take one serial bit (rising serial clock edge)
    logic latchEn;   // move the assembled word into the result register
    logic chanLoad;  // force the channel counter to the first channel
    logic chanStep;  // advance the channel counter one position
  } dpCtl_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAKE,
    ST_SHIFT,
    ST_DONE,
    ST_GAP
  } seqState_t;

endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SCLK_DIV    = 4,
  parameter int WAKE_CYCLES = 224,
  parameter int GAP_SCLKS   = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   hostEnable,
  output logic   csN,
  output logic   sclk,
  output dpCtl_t ctl
);

  localparam int GAP_CYCLES = GAP_SCLKS * 2 * SCLK_DIV;
  localparam int WAIT_MAX   = (WAKE_CYCLES > GAP_CYCLES) ? WAKE_CYCLES : GAP_CYCLES;
  localparam int WAIT_W     = $clog2(WAIT_MAX + 1);
  localparam int DIV_W      = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
  localparam int BIT_W      = $clog2(DATA_W + 1);

  seqState_t         state;
  logic [WAIT_W-1:0] waitCnt;
  logic [DIV_W-1:0]  divCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic              sclkR;
  logic              divTick;

  assign divTick = (divCnt == DIV_W'(SCLK_DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !hostEnable) begin
      state   <= ST_IDLE;
      waitCnt <= '0;
      divCnt  <= '0;
      bitCnt  <= '0;
      sclkR   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          state   <= ST_WAKE;
          waitCnt <= '0;
        end
        ST_WAKE: begin
          if (waitCnt == WAIT_W'(WAKE_CYCLES - 1)) begin
            state   <= ST_SHIFT;
            waitCnt <= '0;
            divCnt  <= '0;
            bitCnt  <= '0;
          end else begin
            waitCnt <= waitCnt + WAIT_W'(1);
          end
        end
        ST_SHIFT: begin
          if (divTick) begin
            divCnt <= '0;
            if (!sclkR) begin
              sclkR  <= 1'b1;
              bitCnt <= bitCnt + BIT_W'(1);
            end else begin
              sclkR <= 1'b0;
              if (bitCnt == BIT_W'(DATA_W)) state <= ST_DONE;
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        ST_DONE: begin
          state   <= ST_GAP;
          waitCnt <= '0;
        end
        ST_GAP: begin
          if (waitCnt == WAIT_W'(GAP_CYCLES - 1)) begin
            state   <= ST_WAKE;
            waitCnt <= '0;
          end else begin
            waitCnt <= waitCnt + WAIT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign csN  = !((state == ST_WAKE) || (state == ST_SHIFT));
  assign sclk = sclkR;

  always_comb begin
    ctl          = '0;
    ctl.shiftEn  = hostEnable && (state == ST_SHIFT) && divTick && !sclkR;
    ctl.latchEn  = hostEnable && (state == ST_DONE);
    ctl.chanLoad = !hostEnable || (state == ST_IDLE);
    ctl.chanStep = hostEnable && (state == ST_GAP) && (waitCnt == '0);
  end

endmodule

// File: rtl/adc_seq_dp.sv
module adc_seq_dp
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  dpCtl_t            ctl,
  input  logic              serialIn,
  input  logic [CHAN_W-1:0] cfgFirst,
  input  logic [CHAN_W-1:0] cfgLast,
  output logic [DATA_W-1:0] resultData,
  output logic              dataReady,
  output logic [CHAN_W-1:0] chanSel
);

  logic [DATA_W-1:0] shiftReg;
  logic [DATA_W-1:0] resultReg;
  logic              readyReg;
  logic [CHAN_W-1:0] chanReg;
  logic              singleChan;
  logic              atLast;

  assign singleChan = (cfgLast < cfgFirst);
  assign atLast     = (chanReg == cfgLast);

  // Serial-to-parallel, MSB arrives first
  always_ff @(posedge clk) begin
    if (rst)              shiftReg <= '0;
    else if (ctl.shiftEn) shiftReg <= {shiftReg[DATA_W-2:0], serialIn};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resultReg <= '0;
      readyReg  <= 1'b0;
    end else begin
      readyReg <= ctl.latchEn;
      if (ctl.latchEn) resultReg <= shiftReg;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.chanLoad)  chanReg <= cfgFirst;
    else if (ctl.chanStep) begin
      if (singleChan || atLast) chanReg <= cfgFirst;
      else                      chanReg <= chanReg + CHAN_W'(1);
    end
  end

  assign resultData = resultReg;
  assign dataReady  = readyReg;
  assign chanSel    = chanReg;

endmodule

// File: rtl/serial_adc_seq.sv
module serial_adc_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int CHAN_W      = 3,
  parameter int SCLK_DIV    = 4,
  parameter int WAKE_CYCLES = 224,
  parameter int GAP_SCLKS   = 2,
  localparam int CFG_W      = 2 * CHAN_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hostEnable,
  input  logic [CFG_W-1:0]  cfgWord,
  input  logic              adcDout,
  output logic              adcCsN,
  output logic              adcSclk,
  output logic [CHAN_W-1:0] chanSel,
  output logic [DATA_W-1:0] resultData,
  output logic              dataReady
);

  dpCtl_t ctl;
  logic   unusedCfgBits;

  assign unusedCfgBits = ^cfgWord[CFG_W-1:2*CHAN_W];

  adc_seq_ctrl #(
    .DATA_W(DATA_W), .SCLK_DIV(SCLK_DIV),
    .WAKE_CYCLES(WAKE_CYCLES), .GAP_SCLKS(GAP_SCLKS)
  ) uCtrl (
    .clk(clk), .rst(rst), .hostEnable(hostEnable),
    .csN(adcCsN), .sclk(adcSclk), .ctl(ctl)
  );

  adc_seq_dp #(.DATA_W(DATA_W), .CHAN_W(CHAN_W)) uDp (
    .clk(clk), .rst(rst), .ctl(ctl), .serialIn(adcDout),
    .cfgFirst(cfgWord[CHAN_W-1:0]),
    .cfgLast(cfgWord[2*CHAN_W-1:CHAN_W]),
    .resultData(resultData), .dataReady(dataReady), .chanSel(chanSel)
  );

endmodule

// File: rtl/serial_adc_seq_chk.sv
module serial_adc_seq_chk #(
  parameter int DATA_W      = 16,
  parameter int CHAN_W      = 3,
  parameter int WAKE_CYCLES = 224
) (
  input logic              clk,
  input logic              rst,
  input logic              hostEnable,
  input logic              adcCsN,
  input logic              adcSclk,
  input logic [CHAN_W-1:0] chanSel,
  input logic [DATA_W-1:0] resultData,
  input logic              dataReady
);

  logic [15:0] csLowCnt;

  always_ff @(posedge clk) begin
    if (rst || adcCsN)         csLowCnt <= '0;
    else if (csLowCnt != '1)   csLowCnt <= csLowCnt + 16'd1;
  end

  AST_CS_HIGH_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !hostEnable |=> adcCsN); // R2
  AST_NO_READY_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !hostEnable |=> !dataReady); // R10
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    adcCsN |-> !adcSclk); // R2
  AST_WAKE_BEFORE_SCLK: assert property (@(posedge clk) disable iff (rst)
    $rose(adcSclk) |-> (csLowCnt >= 16'(WAKE_CYCLES))); // R3
  AST_READY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    dataReady |=> !dataReady); // R5
  AST_RESULT_ONLY_ON_READY: assert property (@(posedge clk) disable iff (rst)
    !$stable(resultData) |-> dataReady); // R5
  AST_CHAN_HELD_IN_CONV: assert property (@(posedge clk) disable iff (rst)
    (!adcCsN && !$past(adcCsN)) |-> $stable(chanSel)); // R9
  AST_CHAN_HELD_AT_READY: assert property (@(posedge clk) disable iff (rst)
    dataReady |-> $stable(chanSel)); // R9

endmodule

bind serial_adc_seq serial_adc_seq_chk #(
  .DATA_W(DATA_W), .CHAN_W(CHAN_W), .WAKE_CYCLES(WAKE_CYCLES)
) uChk (
  .clk(clk), .rst(rst), .hostEnable(hostEnable), .adcCsN(adcCsN),
  .adcSclk(adcSclk), .chanSel(chanSel), .resultData(resultData),
  .dataReady(dataReady)
);

// File: tb/tb_serial_adc_seq.sv
`timescale 1ns/1ps
module tb_serial_adc_seq;

  localparam int W = 224;
  localparam int D = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostEnable = 1'b0;
  logic [7:0]  cfgWord = 8'h2D;
  logic        adcDout = 1'b0;
  logic        adcCsN;
  logic        adcSclk;
  logic [2:0]  chanSel;
  logic [15:0] resultData;
  logic        dataReady;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  serial_adc_seq #(.SCLK_DIV(D), .WAKE_CYCLES(W)) dut (
    .clk(clk), .rst(rst), .hostEnable(hostEnable), .cfgWord(cfgWord),
    .adcDout(adcDout), .adcCsN(adcCsN), .adcSclk(adcSclk),
    .chanSel(chanSel), .resultData(resultData), .dataReady(dataReady)
  );

  // Converter model: new MSB on chip select fall, next bit on each serial clock fall
  logic [15:0] modelWord = '0;
  logic [2:0]  modelChan = '0;
  int          bitIdx = 15;
  int          convIdx = 0;

  always @(negedge adcCsN) begin
    modelWord = 16'hA5C3 ^ 16'(convIdx * 16'h3B1D) ^ {chanSel, 13'd0};
    if (convIdx % 7 == 3) modelWord = 16'h8001;
    modelChan = chanSel;
    convIdx   = convIdx + 1;
    bitIdx    = 15;
    adcDout   = modelWord[15];
  end

  always @(negedge adcSclk) begin
    if (!adcCsN && bitIdx > 0) begin
      bitIdx  = bitIdx - 1;
      adcDout = modelWord[bitIdx];
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic waitReady();
    @(negedge clk);
    while (!dataReady) @(negedge clk);
  endtask

  // cfg byte, then expected channel for four consecutive results
  localparam logic [19:0] VEC [0:5] = '{
    {8'h18, 3'd0, 3'd1, 3'd2, 3'd3},   // 0..3
    {8'hE2, 3'd2, 3'd3, 3'd4, 3'd2},   // 2..4, top bits set, wraps
    {8'h2D, 3'd5, 3'd5, 3'd5, 3'd5},   // single channel 5
    {8'h16, 3'd6, 3'd6, 3'd6, 3'd6},   // last<first
    {8'h3E, 3'd6, 3'd7, 3'd6, 3'd7},   // 6..7 wrap
    {8'h38, 3'd0, 3'd1, 3'd2, 3'd3}    // full range start
  };

  initial begin
    // R1: reset state
    repeat (4) @(negedge clk);
    check(adcCsN == 1'b1, "R1 csN", 32'(adcCsN), 1);
    check(adcSclk == 1'b0, "R1 sclk", 32'(adcSclk), 0);
    check(resultData == 16'h0, "R1 result", 32'(resultData), 0);
    check(dataReady == 1'b0, "R1 ready", 32'(dataReady), 0);
    check(chanSel == 3'd5, "R1 chan", 32'(chanSel), 5);
    rst = 1'b0;
    @(negedge clk);
    check(adcCsN == 1'b1 && chanSel == 3'd5, "R1 after release", 32'({adcCsN, chanSel}), 32'h0D);

    for (int v = 0; v < 6; v++) begin
      hostEnable = 1'b0;
      cfgWord    = VEC[v][19:12];
      repeat (3) @(negedge clk);
      check(chanSel == cfgWord[2:0], "R2 chan held first", 32'(chanSel), 32'(cfgWord[2:0]));
      hostEnable = 1'b1;
      for (int k = 0; k < 4; k++) begin
        logic [2:0] expChan;
        expChan = VEC[v][11 - 3*k -: 3];
        waitReady();
        check(resultData == modelWord, "R4 R5 result word", 32'(resultData), 32'(modelWord));
        check(chanSel == expChan, "R7 R8 chan at ready", 32'(chanSel), 32'(expChan));
        check(modelChan == expChan, "R9 chan at conversion", 32'(modelChan), 32'(expChan));
        @(negedge clk);
        check(dataReady == 1'b0, "R5 single pulse", 32'(dataReady), 0);
      end
    end

    // R2: disabled, nothing happens
    hostEnable = 1'b0;
    cfgWord    = 8'h1B;
    begin
      int bad = 0;
      for (int i = 0; i < 1000; i++) begin
        @(negedge clk);
        if (!adcCsN || adcSclk || dataReady || chanSel != 3'd3) bad++;
      end
      check(bad == 0, "R2 idle while disabled", 32'(bad), 0);
    end

    // R3, R4, R6: timing of one conversion
    cfgWord    = 8'h18;
    hostEnable = 1'b1;
    begin
      int wake = 0;
      int rises = 0;
      int gap = 0;
      logic prevSclk;
      @(negedge clk);
      while (adcCsN) @(negedge clk);
      while (!adcSclk) begin @(negedge clk); wake++; end
      check(wake >= W, "R3 wake delay", 32'(wake), 32'(W));
      rises = 1;
      prevSclk = 1'b1;
      while (!dataReady) begin
        @(negedge clk);
        if (adcSclk && !prevSclk) rises++;
        prevSclk = adcSclk;
      end
      check(rises == 16, "R4 rising edges", 32'(rises), 16);
      while (!adcCsN) @(negedge clk);
      while (adcCsN) begin gap++; @(negedge clk); end
      check(gap >= 4 * D, "R6 gap between conversions", 32'(gap), 32'(4 * D));
    end

    // R10: abort mid-shift
    begin
      int rises = 0;
      int bad = 0;
      logic prevSclk = 1'b0;
      logic [15:0] held;
      while (!adcCsN) @(negedge clk);
      while (adcCsN) @(negedge clk);
      while (rises < 5) begin
        @(negedge clk);
        if (adcSclk && !prevSclk) rises++;
        prevSclk = adcSclk;
      end
      held = resultData;
      hostEnable = 1'b0;
      @(negedge clk);
      check(adcCsN == 1'b1, "R10 cs released", 32'(adcCsN), 1);
      for (int i = 0; i < 500; i++) begin
        @(negedge clk);
        if (dataReady || resultData != held) bad++;
      end
      check(bad == 0, "R10 no ready, result kept", 32'(bad), 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule